// File: doc/BRIEF.md
# Fractional M/N:D Root Clock Generator

The block derives one output clock from a set of source clocks. Each source appears as a strobe input, `src_tick`, that pulses in the reference clock domain once for every edge of that source. The block picks one source and runs it through an integer pre-divider with half-step resolution. It can then run the result through a fractional M/N accumulator whose output duty is set by a programmable threshold. `clk_out` is a register in the reference domain.

Software programs a shadow configuration through a simple word-wide register port. None of those settings reach the output until the update bit in the command register is written. A dynamic-frequency mode takes the settings from a small table of performance levels instead, indexed by the `perf_lvl` input. Every switch of settings waits for a cycle where `clk_out` is low. The switch then restarts the dividers, so the output never carries a runt high pulse.

Top module: `mnd_root_clkgen`

## Requirements
- R1: After reset `clk_out` is 0, the command register (address 0) reads 0, and the active settings are source 0 with the pre-divider bypassed.
- R2: With pre-divider field (config bits [4:0]) equal to 0 or 1, `clk_out` changes level on every tick of the selected source: it rises on the first tick after a commit and falls on the next.
- R3: Writes to the config (address 1), M (2), N (3) and D (4) registers do not change `clk_out` until an update is committed.
- R4: Writing 1 to command bit 0 sets a busy flag, read back at command bit 0. The pending settings are committed in the first later cycle in which `clk_out` is low, and the flag then clears. A commit forces `clk_out` low and restarts both counters at zero.
- R5: A pre-divider value P of 2 or more gives an output period of P+1 source ticks. The output rises on the first tick and falls after floor((P+1)/2) ticks, so an odd division gives a half-integer ratio.
- R6: Config bits [9:8] select which `src_tick` bit drives the divider.
- R7: With config bits [13:12] equal to 2 (dual-edge) and M nonzero, each pre-divided edge advances an accumulator by M modulo N. Here N is recovered as (~Nreg & 0xFFFF) + M. `clk_out` is then high exactly when twice the accumulator is below H = ~Dreg & 0xFFFF.
- R8: With M equal to 0, or with config bits [13:12] not equal to 2, the accumulator is bypassed and only the pre-divider shapes `clk_out`.
- R9: Command bit 1 enables table mode. Level L has config, M, N and D registers at addresses 8+4L+0..3, with the same encodings, and `perf_lvl` selects the level in use.
- R10: In table mode a change of `perf_lvl`, as well as entry into or exit from table mode, is committed at the next low point of `clk_out`, the same way an update is.
- R11: Every shadow and table register reads back the value written to it, in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | SRCS | One edge strobe per source clock |
| perf_lvl | input | LW | Performance level used in table mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational on addr |
| clk_out | output | 1 | Generated clock |

## Verification
The sources tick at four different rates: every cycle, every second cycle, every third cycle, and four cycles out of five. A wrong source selection therefore shows up as a different output rhythm.

The pre-divider is run bypassed, at an odd value (half-integer ratio) and at a larger value. Together these separate the rise and fall positions from the period length.

The accumulator is run with M=1, N=4 and with M=3, N=8. The second setting makes the modulo wrap uneven, which exposes errors in decoding N and D.

The table mode walks three levels and then leaves. Some updates are issued while the output is high, to show that commits are held back until it is low.

// File: rtl/mnd_root_clkgen.sv
module mnd_root_clkgen #(
  parameter int SRCS   = 4,
  parameter int LEVELS = 4,
  parameter int W      = 16,
  parameter int PW     = 5,
  parameter int AW     = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SRCS-1:0]           src_tick,
  input  logic [$clog2(LEVELS)-1:0] perf_lvl,
  input  logic                      wr_en,
  input  logic [AW-1:0]             addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic                      clk_out
);
  localparam int SW    = $clog2(SRCS);
  localparam int LW    = $clog2(LEVELS);
  localparam int TBASE = 8;
  localparam int TEND  = TBASE + 4 * LEVELS;
  localparam logic [1:0] DUAL = 2'd2;

  logic [15:0] cfg_sh;
  logic [W-1:0] m_sh, n_sh, d_sh;
  logic [15:0] tcfg [LEVELS];
  logic [W-1:0] tm [LEVELS];
  logic [W-1:0] tn [LEVELS];
  logic [W-1:0] td [LEVELS];
  logic upd_pend, cmd_dfs, dfs_act;
  logic [LW-1:0] lvl_act;

  logic [PW-1:0] a_pre;
  logic [SW-1:0] a_src;
  logic          a_mnd;
  logic [W-1:0]  a_m, a_n, a_h;
  logic [PW-1:0] pdcnt;
  logic [W-1:0]  acc;

  logic [AW-1:0] toff;
  logic [LW-1:0] tix;
  logic          in_tbl;
  assign toff   = addr - AW'(TBASE);
  assign tix    = toff[LW+1:2];
  assign in_tbl = (addr >= AW'(TBASE)) && (addr < AW'(TEND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sh <= '0; m_sh <= '0; n_sh <= '0; d_sh <= '0;
      upd_pend <= 1'b0; cmd_dfs <= 1'b0;
      for (int i = 0; i < LEVELS; i++) begin
        tcfg[i] <= '0; tm[i] <= '0; tn[i] <= '0; td[i] <= '0;
      end
    end else begin
      if (wr_en && addr == '0 && wdata[0]) upd_pend <= 1'b1;
      else if (commit) upd_pend <= 1'b0;
      if (wr_en) begin
        if (addr == AW'(0)) cmd_dfs <= wdata[1];
        if (addr == AW'(1)) cfg_sh <= wdata[15:0];
        if (addr == AW'(2)) m_sh <= wdata[W-1:0];
        if (addr == AW'(3)) n_sh <= wdata[W-1:0];
        if (addr == AW'(4)) d_sh <= wdata[W-1:0];
        if (in_tbl) begin
          case (addr[1:0])
            2'd0: tcfg[tix] <= wdata[15:0];
            2'd1: tm[tix]   <= wdata[W-1:0];
            2'd2: tn[tix]   <= wdata[W-1:0];
            default: td[tix] <= wdata[W-1:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(0)) rdata[1:0] = {cmd_dfs, upd_pend};
    else if (addr == AW'(1)) rdata[15:0] = cfg_sh;
    else if (addr == AW'(2)) rdata[W-1:0] = m_sh;
    else if (addr == AW'(3)) rdata[W-1:0] = n_sh;
    else if (addr == AW'(4)) rdata[W-1:0] = d_sh;
    else if (in_tbl) begin
      case (addr[1:0])
        2'd0: rdata[15:0] = tcfg[tix];
        2'd1: rdata[W-1:0] = tm[tix];
        2'd2: rdata[W-1:0] = tn[tix];
        default: rdata[W-1:0] = td[tix];
      endcase
    end
  end

  logic [15:0]  s_cfg;
  logic [W-1:0] s_m, s_n, s_d;
  assign s_cfg = cmd_dfs ? tcfg[perf_lvl] : cfg_sh;
  assign s_m   = cmd_dfs ? tm[perf_lvl]   : m_sh;
  assign s_n   = cmd_dfs ? tn[perf_lvl]   : n_sh;
  assign s_d   = cmd_dfs ? td[perf_lvl]   : d_sh;

  logic commit_req, commit;
  assign commit_req = upd_pend || (cmd_dfs != dfs_act) || (cmd_dfs && perf_lvl != lvl_act);
  assign commit     = commit_req && !clk_out;

  logic [PW:0]   len;
  logic [PW-1:0] half, last;
  logic          tick, rise, fall, ev;
  logic [W:0]    sum;
  logic [W-1:0]  acc_nx;
  logic          hi_nx;
  assign tick   = src_tick[a_src];
  assign len    = (a_pre < PW'(2)) ? (PW+1)'(2) : {1'b0, a_pre} + 1'b1;
  assign half   = len[PW:1];
  assign last   = PW'(len - 1'b1);
  assign rise   = pdcnt == '0;
  assign fall   = pdcnt == half;
  assign ev     = tick && (rise || fall);
  assign sum    = {1'b0, acc} + {1'b0, a_m};
  assign acc_nx = (sum >= {1'b0, a_n}) ? W'(sum - {1'b0, a_n}) : sum[W-1:0];
  assign hi_nx  = {acc_nx, 1'b0} < {1'b0, a_h};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pre <= '0; a_src <= '0; a_mnd <= 1'b0;
      a_m <= '0; a_n <= '0; a_h <= '0;
      pdcnt <= '0; acc <= '0; clk_out <= 1'b0;
      dfs_act <= 1'b0; lvl_act <= '0;
    end else if (commit) begin
      a_pre   <= s_cfg[PW-1:0];
      a_src   <= s_cfg[8 +: SW];
      a_mnd   <= (s_cfg[13:12] == DUAL) && (s_m != '0);
      a_m     <= s_m;
      a_n     <= ~s_n + s_m;
      a_h     <= ~s_d;
      pdcnt   <= '0;
      acc     <= '0;
      clk_out <= 1'b0;
      dfs_act <= cmd_dfs;
      lvl_act <= perf_lvl;
    end else if (tick) begin
      pdcnt <= (pdcnt == last) ? '0 : pdcnt + 1'b1;
      if (ev) begin
        if (a_mnd) begin
          acc     <= acc_nx;
          clk_out <= hi_nx;
        end else begin
          clk_out <= rise;
        end
      end
    end
  end

  // R4
  busy_clears_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_pend) |-> !$past(clk_out));
  // R4
  commit_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (pdcnt == '0 && acc == '0 && !clk_out));
  // R5
  pdcnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pdcnt} < len);
  // R7
  acc_below_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_mnd |-> acc < a_n);
  // R2
  out_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> $past(tick));
  // R10
  level_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dfs_act && $past(clk_out)) |-> $stable(lvl_act));
endmodule

// File: tb/mnd_root_clkgen_tb.sv
module mnd_root_clkgen_tb;
  localparam int SRCS = 4, LEVELS = 4, W = 16, PW = 5, AW = 6;

  logic clk = 0, rst_n = 0;
  logic [SRCS-1:0] src_tick = '0;
  logic [1:0] perf_lvl = '0;
  logic wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic clk_out;

  mnd_root_clkgen #(.SRCS(SRCS), .LEVELS(LEVELS), .W(W), .PW(PW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .perf_lvl(perf_lvl),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .clk_out(clk_out));

  always #10 clk = ~clk;

  typedef struct { bit v; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, k = 0;
  logic [1:0] cur_lv = '0;

  // reference state
  bit [15:0] r_cfg, r_m, r_n, r_d;
  bit [15:0] t_cfg [4];
  bit [15:0] t_m [4];
  bit [15:0] t_n [4];
  bit [15:0] t_d [4];
  bit r_pend, r_dfs, r_dfs_act, r_out, r_mnd;
  bit [1:0] r_lvl, r_src;
  int r_pre, r_pd, r_acc, r_mm, r_nn, r_hh;

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (clk_out !== it.v) begin
        errors++;
        $display("FAIL %s: clk_out=%0b expected %0b at t=%0t", it.tag, clk_out, it.v, $time);
      end
    end
  end

  task automatic model_step(bit w, logic [AW-1:0] a, logic [31:0] d, logic [SRCS-1:0] tk, logic [1:0] lv);
    bit creq, tick, rise, fall;
    int len, half;
    bit [15:0] c, mm, nn, dd;
    creq = r_pend || (r_dfs != r_dfs_act) || (r_dfs && lv != r_lvl);
    tick = tk[r_src];
    len = (r_pre < 2) ? 2 : r_pre + 1;
    half = len / 2;
    if (creq && !r_out) begin
      c  = r_dfs ? t_cfg[lv] : r_cfg;
      mm = r_dfs ? t_m[lv] : r_m;
      nn = r_dfs ? t_n[lv] : r_n;
      dd = r_dfs ? t_d[lv] : r_d;
      r_pre = c[4:0]; r_src = c[9:8];
      r_mnd = (c[13:12] == 2) && (mm != 0);
      r_mm = mm; r_nn = ((~nn) + mm) & 16'hFFFF; r_hh = (~dd) & 16'hFFFF;
      r_pd = 0; r_acc = 0; r_out = 0;
      r_dfs_act = r_dfs; r_lvl = lv; r_pend = 0;
    end else if (tick) begin
      rise = (r_pd == 0); fall = (r_pd == half);
      if (rise || fall) begin
        if (r_mnd) begin
          r_acc = r_acc + r_mm;
          if (r_acc >= r_nn) r_acc = r_acc - r_nn;
          r_out = (2 * r_acc) < r_hh;
        end else r_out = rise;
      end
      r_pd = (r_pd == len - 1) ? 0 : r_pd + 1;
    end
    if (w) begin
      if (a == 0) begin if (d[0]) r_pend = 1; r_dfs = d[1]; end
      else if (a == 1) r_cfg = d[15:0];
      else if (a == 2) r_m = d[15:0];
      else if (a == 3) r_n = d[15:0];
      else if (a == 4) r_d = d[15:0];
      else if (a >= 8 && a < 24) begin
        case ((a - 8) % 4)
          0: t_cfg[(a - 8) / 4] = d[15:0];
          1: t_m[(a - 8) / 4] = d[15:0];
          2: t_n[(a - 8) / 4] = d[15:0];
          default: t_d[(a - 8) / 4] = d[15:0];
        endcase
      end
    end
  endtask

  task automatic cyc(bit w, logic [AW-1:0] a, logic [31:0] d, bit rchk, logic [31:0] rexp, string tag);
    logic [SRCS-1:0] tk;
    item_t it;
    @(negedge clk);
    tk[0] = 1'b1; tk[1] = (k % 2 == 0); tk[2] = (k % 3 == 0); tk[3] = (k % 5 != 0);
    k++;
    src_tick = tk; wr_en = w; addr = a; wdata = d; perf_lvl = cur_lv;
    #1;
    if (rchk) begin
      checks++;
      if (rdata !== rexp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h (addr %0d)", tag, rdata, rexp, a);
      end
    end
    model_step(w, a, d, tk, cur_lv);
    it.v = r_out; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
    cyc(1, a, d, 0, 0, tag);
  endtask
  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string tag);
    cyc(0, a, 0, 1, e, tag);
  endtask
  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask
  task automatic wait_idle(string tag);
    for (int i = 0; i < 200 && r_pend; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (clk_out !== 1'b0 || rdata !== 32'd0) begin
      errors++;
      $display("FAIL R1: clk_out=%0b rdata=%h expected 0 0", clk_out, rdata);
    end
    rst_n = 1;
    rd(0, 0, "R1 cmd reads zero");
    run(10, "R2 bypass toggles per tick");

    wr(1, 32'h0103, "R3 shadow write");
    run(10, "R3 staged config not applied");
    rd(1, 32'h0103, "R11 cfg readback");

    wr(0, 32'h1, "R4 update issued");
    rd(0, {30'd0, r_dfs, r_pend}, "R4 busy readback");
    wait_idle("R4 commit at low point");
    rd(0, 0, "R4 busy cleared");
    run(16, "R6 source 1 with pre-divide 3");

    wr(1, 32'h0002, "R5 odd pre-divide");
    wr(0, 32'h1, "R5 update");
    run(16, "R5 half-integer ratio");
    wr(1, 32'h0309, "R5 pre-divide 9 on source 3");
    wr(0, 32'h1, "R6 update");
    run(30, "R6 source 3 divide 10");

    wr(2, 32'h0001, "R7 M");
    wr(3, 32'hFFFC, "R7 N");
    wr(4, 32'hFFFB, "R7 D");
    wr(1, 32'h2000, "R7 dual-edge cfg");
    wr(0, 32'h1, "R7 update");
    run(24, "R7 M1 N4");
    rd(3, 32'hFFFC, "R11 N readback");

    wr(2, 32'h0003, "R7 M3");
    wr(3, 32'hFFFA, "R7 N8");
    wr(4, 32'hFFF7, "R7 H8");
    wr(1, 32'h2203, "R7 dual-edge src2 pre3");
    wr(0, 32'h1, "R7 update");
    run(60, "R7 M3 N8 uneven wrap");

    wr(1, 32'h0000, "R8 mode not dual");
    wr(0, 32'h1, "R8 update");
    run(12, "R8 accumulator bypassed");
    wr(1, 32'h2000, "R8 dual with M0");
    wr(2, 32'h0000, "R8 M zero");
    wr(0, 32'h1, "R8 update");
    run(12, "R8 M zero bypass");

    wr(8, 32'h0002, "R9 lvl0 cfg");
    wr(12, 32'h2000, "R9 lvl1 cfg");
    wr(13, 32'h0001, "R9 lvl1 M");
    wr(14, 32'hFFFC, "R9 lvl1 N");
    wr(15, 32'hFFFB, "R9 lvl1 D");
    wr(16, 32'h0205, "R9 lvl2 cfg");
    rd(14, 32'hFFFC, "R11 table readback");
    cur_lv = 2'd0;
    wr(0, 32'h2, "R9 enable table mode");
    run(15, "R9 level 0");
    cur_lv = 2'd1;
    run(24, "R10 level 1 switch");
    cur_lv = 2'd2;
    run(30, "R10 level 2 switch");
    rd(0, 32'h2, "R9 mode bit readback");
    wr(0, 32'h0, "R10 leave table mode");
    run(15, "R10 back to shadow");

    run(4, "drain");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule